// File: doc/BRIEF.md
# Oversampling Start-Stop Character Receiver

This block turns a start-stop serial line into parallel characters for a host. A one-cycle enable pulse `tick` arrives at sixteen times the bit rate and paces all line sampling. The line is first passed through a two-flop synchronizer. The receiver then waits in idle for a low level. It accepts that low level as a start bit only when it stays low for half a bit time. After that it samples each following bit in its middle.

The character length can be set to 5, 6, 7 or 8 bits. Parity can be set to none, odd or even. Only the data bits reach the host, right-aligned in `rx_data`. Each character carries three flags: a framing error, a parity error and an overrun. The host takes a character by pulsing `rd_ack`.

Top module: `async_char_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_frame_err`, `rx_par_err` and `rx_overrun` are 0 and `rx_data` is 0.
- R2: The receiver's timing advances only in cycles where `tick` is 1. The line level is evaluated on ticks only, after a two-stage synchronizer.
- R3: A low level that lasts fewer than 8 consecutive ticks is discarded. No character results, and the receiver returns to idle.
- R4: Data bits arrive least significant first. The count is `cfg_len`+5 (`cfg_len` 0..3 gives 5..8 bits). The character appears in `rx_data[len-1:0]`, and the bits above it read 0.
- R5: `cfg_par` selects the parity mode: 0 means none, 1 means odd, 2 means even, and 3 is treated as none. When parity is enabled, one parity bit sits between the last data bit and the stop bit.
- R6: If the received parity bit breaks the selected rule, the character is delivered with `rx_par_err`=1. Under odd parity, the data ones plus the parity bit must total an odd count; under even parity, an even count.
- R7: If the stop-bit sample is 0, the character is still delivered, with `rx_frame_err`=1 and the data bits intact.
- R8: After a framing error, no new start bit is searched for until the line has been seen at 1 on a tick.
- R9: Every completed character sets `rx_valid`, whether or not an error was found.
- R10: When `rd_ack` is 1 in a cycle where no character completes, `rx_valid` is 0 from the next cycle on.
- R11: If a character completes while `rx_valid` is 1 and `rd_ack` is 0, the new character replaces the old one and `rx_overrun` is 1. Otherwise a completed character carries `rx_overrun`=0.
- R12: While no character completes, `rx_data` and the three flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par | input | 2 | Parity mode: 0 none, 1 odd, 2 even, 3 none |
| rd_ack | input | 1 | Host read strobe |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | Character available |
| rx_frame_err | output | 1 | Stop bit was sampled low |
| rx_par_err | output | 1 | Parity mismatch |
| rx_overrun | output | 1 | Previous unread character was replaced |

## Verification
The hardest behaviour to reach from the ports is the recovery after a framing error. The stimulus sends a zero stop bit and then holds the line low for two more bit times. A receiver that searched for a new start bit at once would assemble a spurious character from that held-low stretch. The clean character that follows must arrive alone and unflagged. The glitch filter is driven with a low pulse shorter than half a bit, at a tick rate of half the clock, so the pulse is counted in ticks rather than in clock cycles.

// File: rtl/async_char_rx_pkg.sv
package async_char_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    localparam logic [1:0] PAR_NONE = 2'd0;
    localparam logic [1:0] PAR_ODD  = 2'd1;
    localparam logic [1:0] PAR_EVEN = 2'd2;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import async_char_rx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int MINW = 5,
    parameter int MAXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            line,
    input  logic [1:0]      cfg_len,
    input  logic [1:0]      cfg_par,
    output logic            done,
    output logic [MAXW-1:0] word,
    output logic            par_err,
    output logic            frm_err
);
    localparam int HALF = OSR / 2;
    localparam int CW   = $clog2(OSR);
    localparam int IW   = $clog2(MAXW);
    localparam int NW   = $clog2(MAXW + 1);

    typedef struct packed {
        rx_state_e       st;
        logic [CW-1:0]   cnt;
        logic [IW-1:0]   idx;
        logic [MAXW-1:0] sh;
        logic            px;
        logic            perr;
        logic            ferr;
        logic            done;
    } fsm_t;

    fsm_t r_q, r_d;

    logic [NW-1:0] nbits;
    logic [IW-1:0] last_idx;
    logic          par_en;
    logic          full_bit;

    always_comb begin
        nbits    = NW'(MINW) + NW'(cfg_len);
        last_idx = IW'(nbits - NW'(1));
        par_en   = (cfg_par == PAR_ODD) || (cfg_par == PAR_EVEN);
        full_bit = (r_q.cnt == CW'(OSR - 1));
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (tick) begin
            case (r_q.st)
                RX_IDLE: begin
                    if (!line) begin
                        r_d.st  = RX_START;
                        r_d.cnt = CW'(1);
                    end
                end
                RX_START: begin
                    if (line) begin
                        r_d.st = RX_IDLE;
                    end else if (r_q.cnt == CW'(HALF - 1)) begin
                        r_d.st   = RX_DATA;
                        r_d.cnt  = '0;
                        r_d.idx  = '0;
                        r_d.sh   = '0;
                        r_d.px   = 1'b0;
                        r_d.perr = 1'b0;
                        r_d.ferr = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                RX_DATA: begin
                    if (full_bit) begin
                        r_d.cnt = '0;
                        r_d.sh  = {line, r_q.sh[MAXW-1:1]};
                        r_d.px  = r_q.px ^ line;
                        if (r_q.idx == last_idx) begin
                            r_d.st = par_en ? RX_PARITY : RX_STOP;
                        end else begin
                            r_d.idx = r_q.idx + IW'(1);
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                RX_PARITY: begin
                    if (full_bit) begin
                        r_d.cnt = '0;
                        if (cfg_par == PAR_ODD) r_d.perr = ~(r_q.px ^ line);
                        else                    r_d.perr = r_q.px ^ line;
                        r_d.st = RX_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                RX_STOP: begin
                    if (full_bit) begin
                        r_d.cnt  = '0;
                        r_d.done = 1'b1;
                        r_d.ferr = ~line;
                        r_d.st   = line ? RX_IDLE : RX_WAIT_HIGH;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                RX_WAIT_HIGH: begin
                    if (line) r_d.st = RX_IDLE;
                end
                default: r_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        done    = r_q.done;
        word    = r_q.sh >> (NW'(MAXW) - nbits);
        par_err = r_q.perr;
        frm_err = r_q.ferr;
    end
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
    parameter int MAXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done,
    input  logic [MAXW-1:0] word,
    input  logic            par_err,
    input  logic            frm_err,
    input  logic            rd_ack,
    output logic [MAXW-1:0] data,
    output logic            valid,
    output logic            fe,
    output logic            pe,
    output logic            ov
);
    typedef struct packed {
        logic [MAXW-1:0] data;
        logic            valid;
        logic            fe;
        logic            pe;
        logic            ov;
    } hold_t;

    hold_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (rd_ack) h_d.valid = 1'b0;
        if (done) begin
            h_d.data  = word;
            h_d.valid = 1'b1;
            h_d.fe    = frm_err;
            h_d.pe    = par_err;
            h_d.ov    = h_q.valid & ~rd_ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign data  = h_q.data;
    assign valid = h_q.valid;
    assign fe    = h_q.fe;
    assign pe    = h_q.pe;
    assign ov    = h_q.ov;
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx #(
    parameter int OSR         = 16,
    parameter int MINW        = 5,
    parameter int MAXW        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            rxd,
    input  logic [1:0]      cfg_len,
    input  logic [1:0]      cfg_par,
    input  logic            rd_ack,
    output logic [MAXW-1:0] rx_data,
    output logic            rx_valid,
    output logic            rx_frame_err,
    output logic            rx_par_err,
    output logic            rx_overrun
);
    logic            line_s;
    logic            fsm_done;
    logic [MAXW-1:0] fsm_word;
    logic            fsm_perr;
    logic            fsm_ferr;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    rx_frame_fsm #(.OSR(OSR), .MINW(MINW), .MAXW(MAXW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .line   (line_s),
        .cfg_len(cfg_len),
        .cfg_par(cfg_par),
        .done   (fsm_done),
        .word   (fsm_word),
        .par_err(fsm_perr),
        .frm_err(fsm_ferr)
    );

    rx_hold_reg #(.MAXW(MAXW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (fsm_done),
        .word   (fsm_word),
        .par_err(fsm_perr),
        .frm_err(fsm_ferr),
        .rd_ack (rd_ack),
        .data   (rx_data),
        .valid  (rx_valid),
        .fe     (rx_frame_err),
        .pe     (rx_par_err),
        .ov     (rx_overrun)
    );
endmodule

// File: rtl/async_char_rx_checker.sv
module async_char_rx_checker #(
    parameter int MAXW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            rd_ack,
    input logic            done,
    input logic [MAXW-1:0] rx_data,
    input logic            rx_valid,
    input logic            rx_frame_err,
    input logic            rx_par_err,
    input logic            rx_overrun
);
    // R2: completion is only produced from a tick cycle
    a_r2_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tick));

    // R9: every completion raises the available flag
    a_r9_valid_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_valid);

    // R10: read strobe without a completion drops the flag
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !done) |=> !rx_valid);

    // R11: completion over an unread character reports overrun
    a_r11_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_valid && !rd_ack) |=> rx_overrun);

    // R11: completion over a read or empty holder clears overrun
    a_r11_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (!rx_valid || rd_ack)) |=> !rx_overrun);

    // R12: outputs hold while nothing completes
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(rx_data) && $stable(rx_frame_err)
                   && $stable(rx_par_err) && $stable(rx_overrun)));
endmodule

bind async_char_rx async_char_rx_checker #(.MAXW(MAXW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rd_ack      (rd_ack),
    .done        (fsm_done),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_frame_err(rx_frame_err),
    .rx_par_err  (rx_par_err),
    .rx_overrun  (rx_overrun)
);

// File: tb/tb_async_char_rx.sv
`timescale 1ns/1ps
module tb_async_char_rx;
    localparam int BITCLK = 32; // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd0;
    logic [1:0] cfg_par = 2'd0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_frame_err, rx_par_err, rx_overrun;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    async_char_rx dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
        .rx_par_err(rx_par_err), .rx_overrun(rx_overrun)
    );

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    function automatic logic par_bit(input int len, input int par, input logic [7:0] d);
        int ones;
        ones = $countones(d & 8'((1 << len) - 1));
        return (par == 1) ? ~ones[0] : ones[0];
    endfunction

    task automatic send_char(input int len, input int par, input logic [7:0] d,
                             input bit flip, input logic stop_v);
        bit_time(1'b0);
        for (int i = 0; i < len; i++) bit_time(d[i]);
        if (par == 1 || par == 2) bit_time(par_bit(len, par, d) ^ flip);
        bit_time(stop_v);
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, m;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rx_valid == 0 && rx_frame_err == 0 && rx_par_err == 0 && rx_overrun == 0,
            "R1 flags after reset", {rx_valid, rx_frame_err, rx_par_err, rx_overrun}, 0);
        chk(rx_data == 0, "R1 data after reset", rx_data, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // R2 R4 R5 R9 R10: sweep every length and parity mode
        for (int len = 5; len <= 8; len++) begin
            for (int par = 0; par < 4; par++) begin
                cfg_len = 2'(len - 5);
                cfg_par = 2'(par);
                m = 8'((1 << len) - 1);
                for (int k = 0; k < 6; k++) begin
                    d = (k == 5) ? m : 8'((k * 37 + len * 11 + par * 3) & m);
                    send_char(len, par, d, 1'b0, 1'b1);
                    bit_time(1'b1);
                    chk(rx_valid == 1, "R9 valid after char", rx_valid, 1);
                    chk(rx_data == d, "R4 R5 R2 data", rx_data, d);
                    chk(rx_par_err == 0 && rx_frame_err == 0 && rx_overrun == 0,
                        "R5 clean flags", {rx_frame_err, rx_par_err, rx_overrun}, 0);
                    ack();
                    @(negedge clk);
                    chk(rx_valid == 0, "R10 ack clears", rx_valid, 0);
                end
            end
        end

        // R3: short low pulse (5 ticks) rejected
        cfg_len = 2'd3; cfg_par = 2'd0;
        rxd = 1'b0;
        repeat (10) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        chk(rx_valid == 0, "R3 glitch ignored", rx_valid, 0);
        send_char(8, 0, 8'hA5, 1'b0, 1'b1);
        bit_time(1'b1);
        chk(rx_valid == 1 && rx_data == 8'hA5, "R3 char after glitch", rx_data, 8'hA5);
        ack();

        // R6: parity mismatch, even and odd
        cfg_par = 2'd2;
        send_char(8, 2, 8'h3C, 1'b1, 1'b1);
        bit_time(1'b1);
        chk(rx_par_err == 1 && rx_data == 8'h3C, "R6 even mismatch", {rx_par_err, rx_data}, {1'b1, 8'h3C});
        ack();
        cfg_par = 2'd1;
        send_char(8, 1, 8'h01, 1'b1, 1'b1);
        bit_time(1'b1);
        chk(rx_par_err == 1, "R6 odd mismatch", rx_par_err, 1);
        ack();

        // R7 R8: zero stop bit, line held low afterwards
        cfg_par = 2'd0;
        send_char(8, 0, 8'h5A, 1'b0, 1'b0);
        bit_time(1'b0);
        bit_time(1'b0);
        chk(rx_valid == 1 && rx_frame_err == 1, "R7 framing error", {rx_valid, rx_frame_err}, 2'b11);
        chk(rx_data == 8'h5A, "R7 data kept", rx_data, 8'h5A);
        ack();
        @(negedge clk);
        bit_time(1'b1);
        chk(rx_valid == 0, "R8 no char from held low", rx_valid, 0);
        bit_time(1'b1);
        send_char(8, 0, 8'hC3, 1'b0, 1'b1);
        bit_time(1'b1);
        chk(rx_data == 8'hC3 && rx_frame_err == 0 && rx_overrun == 0,
            "R8 clean char after recovery", rx_data, 8'hC3);
        ack();

        // R11 R12: overrun replaces unread char
        send_char(8, 0, 8'h11, 1'b0, 1'b1);
        bit_time(1'b1);
        bit_time(1'b1);
        chk(rx_valid == 1 && rx_data == 8'h11, "R12 held while unread", rx_data, 8'h11);
        send_char(8, 0, 8'h22, 1'b0, 1'b1);
        bit_time(1'b1);
        chk(rx_data == 8'h22, "R11 newer char kept", rx_data, 8'h22);
        chk(rx_overrun == 1, "R11 overrun set", rx_overrun, 1);
        ack();
        send_char(8, 0, 8'h33, 1'b0, 1'b1);
        bit_time(1'b1);
        chk(rx_overrun == 0 && rx_data == 8'h33, "R11 overrun cleared", rx_overrun, 0);
        ack();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule